// File: doc/BRIEF.md
# Modulus Down-Counter Timer

This block is an 8-bit reloading down-counter that raises a periodic interrupt. Software programs a reload value and a count rate, and the counter then steps down once per selected tick. When it runs out, it reloads itself, latches a sticky underflow flag and, if enabled, drives an interrupt request. The count rate comes from a free-running prescaler. One select code gates the count off, and that code is the state after reset.

The block has a simple synchronous register port. A write is taken on the rising clock edge while the write strobe is high. The read data is combinational from the addressed register. Software clears the flag by writing a one to the flag bit. A write-only preset bit copies the reload value straight into the counter, and is meant for use while the count is stopped. The live count can be read at its own address.

Top module: `modulus_timer`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0x00 and `irq` is low.
- R2: While the select field (control bits 2:0) is 0, the counter holds its value.
- R3: Select codes 1 to 7 produce one count tick every 2^(code-1) clock cycles, taken from a free-running 6-bit prescaler. Each tick that does not underflow lowers the counter by exactly 1.
- R4: A tick that finds the counter at 1 or 0 reloads the counter from the reload register and sets the underflow flag (control bit 6). A reload value N >= 1 therefore gives an underflow every N ticks.
- R5: The underflow flag is sticky. A control write with bit 6 = 1 clears it, and a control write with bit 6 = 0 leaves it unchanged.
- R6: If an underflow and a clearing write fall in the same cycle, the flag stays set.
- R7: `irq` is high exactly when the flag (bit 6) and the interrupt enable (bit 7) are both 1.
- R8: A control write with bit 3 = 1 loads the counter from the reload register. Bits 5:3 of the control register always read 0.
- R9: The address map is as follows. Address 0 is control. Address 1 is the reload register, read/write. Address 2 returns the counter, and writes to it are ignored. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, the following properties:
- a stopped counter never moves;
- a running counter only holds, steps down by one, or reloads;
- the flag cannot drop without a clearing write;
- the reserved control bits read zero;
- the interrupt line matches the enable and flag bits seen through the read port.

The exact tick spacing for each select code is shown only by the directed scenarios, which time the gap between counter changes. The same applies to where the reload falls in the count, the set-over-clear collision, the preset load and the ignored counter writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MOD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

  // control field positions
  localparam int BIT_EN     = 7;
  localparam int BIT_FLAG   = 6;
  localparam int BIT_PRESET = 3;

  typedef struct packed {
    logic loadMod;  // write to reload register
    logic preset;   // copy reload value into counter
    logic tick;     // counter step enable
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] cntVal,
  input  logic [DATA_W-1:0] modVal,
  input  logic              underflow,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output tmrStrobe_t        strb
);
  localparam int NUM_SEL = 1 << SEL_W;

  logic [SEL_W-1:0]   selQ;
  logic               enQ;
  logic               flagQ;
  logic [PRE_W-1:0]   preCnt;
  logic [NUM_SEL-1:0] tapHit;
  logic               ctrlWr;
  logic [DATA_W-1:0]  ctrlView;
  logic               unusedBits;

  assign ctrlWr     = wrEn && (addr == ADDR_CTRL);
  assign unusedBits = ^wrData[DATA_W-1:0];

  // free-running prescaler
  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // tap g fires every 2^(g-1) cycles; tap 0 never fires
  assign tapHit[0] = 1'b0;
  for (genvar g = 1; g < NUM_SEL; g++) begin : g_tap
    if (g == 1) begin : g_every
      assign tapHit[g] = 1'b1;
    end else begin : g_div
      assign tapHit[g] = &preCnt[g-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      enQ   <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      if (ctrlWr) begin
        selQ <= wrData[SEL_W-1:0];
        enQ  <= wrData[BIT_EN];
      end
      if (underflow)                     flagQ <= 1'b1;
      else if (ctrlWr && wrData[BIT_FLAG]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    strb.tick    = tapHit[selQ];
    strb.preset  = ctrlWr && wrData[BIT_PRESET];
    strb.loadMod = wrEn && (addr == ADDR_MOD);
  end

  always_comb begin
    ctrlView              = '0;
    ctrlView[SEL_W-1:0]   = selQ;
    ctrlView[BIT_FLAG]    = flagQ;
    ctrlView[BIT_EN]      = enQ;
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = ctrlView;
      ADDR_MOD:  rdData = modVal;
      ADDR_CNT:  rdData = cntVal;
      default:   rdData = '0;
    endcase
  end

  assign irq = enQ && flagQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] modVal,
  output logic              underflow
);
  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] modQ;
  logic              atEnd;

  assign atEnd     = (cntQ <= DATA_W'(1));
  assign underflow = strb.tick && !strb.preset && atEnd;

  always_ff @(posedge clk) begin
    if (!rstN) modQ <= '0;
    else if (strb.loadMod) modQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cntQ <= '0;
    else if (strb.preset)   cntQ <= modQ;
    else if (strb.tick) begin
      if (atEnd) cntQ <= modQ;
      else       cntQ <= cntQ - 1'b1;
    end
  end

  assign cntVal = cntQ;
  assign modVal = modQ;
endmodule

// File: rtl/modulus_timer.sv
module modulus_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  tmrStrobe_t        strb;
  logic [DATA_W-1:0] cntVal;
  logic [DATA_W-1:0] modVal;
  logic              underflow;

  tmr_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .cntVal(cntVal), .modVal(modVal), .underflow(underflow),
    .rdData(rdData), .irq(irq), .strb(strb)
  );

  tmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cntVal(cntVal), .modVal(modVal), .underflow(underflow)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irq,
  input logic [DATA_W-1:0] cntVal
);
  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && addr == 2'd0 && rdData[2:0] == 3'd0) |=> $stable(cntVal));

  p_step_or_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && addr == 2'd0) && cntVal > DATA_W'(1))
      |=> (cntVal == $past(cntVal) || cntVal == $past(cntVal) - DATA_W'(1)));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(addr == 2'd0 && rdData[6] && !(wrEn && wrData[6])) && addr == 2'd0)
      |-> rdData[6]);

  p_irq_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd0) |-> (irq == (rdData[7] && rdData[6])));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd0) |-> (rdData[5:3] == 3'd0));
endmodule

bind modulus_timer tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .irq(irq), .cntVal(cntVal)
);

// File: tb/sim_modulus_timer.sv
module sim_modulus_timer;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  modulus_timer u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", irq, 0);
    rd(2'd2, v); chk("R1 counter", v, 0);
  endtask

  task automatic t_stop_and_map();
    logic [7:0] v;
    wr(2'd1, 8'd10);
    wr(2'd0, 8'h08);
    rd(2'd2, v); chk("R8 preset load", v, 10);
    rd(2'd0, v); chk("R8 preset bit reads 0", v, 0);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R2 stopped hold", v, 10);
    wr(2'd2, 8'h55);
    rd(2'd2, v); chk("R9 counter write ignored", v, 10);
    rd(2'd1, v); chk("R9 reload readback", v, 10);
    rd(2'd3, v); chk("R9 unused address", v, 0);
    wr(2'd0, 8'h37);
    rd(2'd0, v); chk("R8 reserved bits read 0", v, 8'h07);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_rate();
    for (int k = 1; k <= 7; k++) begin
      logic [7:0] v;
      logic [7:0] prev;
      int first;
      int second;
      wr(2'd1, 8'd200);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h08);
      rd(2'd2, v); chk("R8 preset before run", v, 200);
      wr(2'd0, 8'(k));
      addr = 2'd2;
      #1 prev = rdData;
      first = -1;
      second = -1;
      for (int c = 1; c < 300 && second < 0; c++) begin
        @(negedge clk);
        #1;
        if (rdData != prev) begin
          chk("R3 step by one", rdData, prev - 8'd1);
          if (first < 0) first = c;
          else second = c;
          prev = rdData;
        end
      end
      chk($sformatf("R3 tick gap code %0d", k), second - first, 1 << (k - 1));
    end
    wr(2'd0, 8'h00);
  endtask

  task automatic t_underflow();
    logic [7:0] v;
    int n;
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h01);
    n = 99;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (rdData[6]) begin n = i; break; end
      @(negedge clk);
    end
    chk("R4 cycles to underflow", n, 3);
    addr = 2'd2;
    #0.5 chk("R4 reload value", rdData, 3);
    chk("R7 irq off when disabled", irq, 0);
    wr(2'd0, 8'h80);
    rd(2'd0, v); chk("R5 zero write keeps flag", v, 8'hC0);
    chk("R7 irq on", irq, 1);
    wr(2'd0, 8'hC0);
    rd(2'd0, v); chk("R5 clear flag", v, 8'h80);
    chk("R7 irq off after clear", irq, 0);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h41);
    rd(2'd0, v); chk("R6 set wins over clear", v[6], 1);
    wr(2'd0, 8'h40);
    rd(2'd0, v); chk("R6 set wins on stopping write", v[6], 1);
    wr(2'd0, 8'h40);
    rd(2'd0, v); chk("R5 clear once stopped", v[6], 0);
  endtask

  initial begin
    #(5 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_stop_and_map();
    t_rate();
    t_underflow();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule